// File: doc/BRIEF.md
# Serial Telegram Command Decoder

This block sits behind a serial slave shifter and turns the bytes that the shifter delivers into memory accesses. A telegram opens when the select line (`cs_n`) goes low and closes when it rises. Its first nibble is a command code. A single transfer carries a 12-bit address offset, then one, two or four data bytes. A burst carries an 11-bit length and a full 32-bit address, then up to 2048 bytes. The block sends reads and writes out on a simple request/response port, or to a small internal register file. It returns an acknowledgment byte and the read data as a stream of bytes for the shifter to send back to the master.

A single transfer gets the upper 20 address bits from register 0 of the internal file. Every telegram whose header decodes correctly is acknowledged. When the header is incorrect, the block drops the telegram, sends nothing back and makes no access. Two outputs each give a one-cycle pulse: one when a telegram's write has completed, one when its read data has been queued.

Top module: `tlg_decoder`

## Requirements
- R1: After reset `tx_valid`, `req_valid`, `write_done` and `read_done` are low, and every internal register, including the page register 0, holds zero.
- R2: A single-transfer header is byte 0 = {command[3:0], offset[11:8]} followed by byte 1 = offset[7:0]. A valid single read issues exactly one request with `req_write`=0 and `req_addr` = {register0[31:12], offset}. Its `req_size` is 0 for code 0x1 (1 byte), 1 for code 0x2 (2 bytes) and 2 for code 0x3 (4 bytes).
- R3: The valid commands are 0x1/0x2/0x3 (bus read of 8/16/32 bits), 0x4 (register read), 0x5 (burst read), 0x9/0xA/0xB (bus write of 8/16/32 bits), 0xC (register write) and 0xD (burst write). When a header is accepted, the first byte on the `tx` stream is the code repeated in both nibbles, for example 0xAA.
- R4: The bytes of a single read's response follow the acknowledgment, most significant first. The response is right-justified in `rsp_rdata`. `read_done` pulses for one cycle after the data has been queued.
- R5: A single write collects its 1, 2 or 4 data bytes, most significant first. It then issues one request whose `req_wdata` holds them right-justified. `write_done` pulses for one cycle after the request is accepted.
- R6: Register telegrams (0x4, 0xC) move 32 bits, most significant byte first. They select register offset[11:2]. The read bytes follow the acknowledgment, and a write updates the register and pulses `write_done`. Neither makes a bus request.
- R7: A burst header is six bytes: {command, reserved bit, length[10:8]}, length[7:0], then the address MSB first. The reserved bit is ignored. A burst write issues length+1 one-byte writes at consecutive addresses. `write_done` pulses only after the last of them is accepted.
- R8: A burst read issues its first one-byte read when the header completes and one more for each later byte received, length+1 reads in all. Each returned byte goes on the `tx` stream after the acknowledgment. `read_done` pulses after the last one.
- R9: A telegram with any other command code gets no acknowledgment and makes no request. The rest of its bytes are ignored.
- R10: These single transfers are dropped with no acknowledgment and no access: a 16-bit access at an odd offset, a 32-bit access at an offset that is not a multiple of 4, and a register telegram whose offset is not a multiple of 4 or whose index is NUM_REGS or more.
- R11: If select rises before the header is complete, nothing is sent back and nothing is issued. If it rises before a single write's data is complete, no write is made. If it rises during a burst, no further accesses are issued and `write_done` does not pulse.
- R12: While `req_valid` is high and `req_ready` is low, the request holds its address, data and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Slave select, low during a telegram |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A byte for the master is present |
| tx_byte | output | 8 | Byte for the master |
| req_valid | output | 1 | Access request pending |
| req_ready | input | 1 | Request accepted this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Byte address |
| req_size | output | 2 | 0 = byte, 1 = half word, 2 = word |
| req_wdata | output | 32 | Write data, right-justified |
| rsp_valid | input | 1 | Read data returned |
| rsp_rdata | input | 32 | Read data, right-justified |
| write_done | output | 1 | Telegram write complete pulse |
| read_done | output | 1 | Telegram read data queued pulse |

## Verification
The bench sends misaligned half-word and word accesses. A design with a wrong alignment test would acknowledge them and issue a bus access. It cuts telegrams short in the header, in the data of a single write and in the middle of a burst. A design that commits too early would issue a write or pulse `write_done` for data it never got in full. It writes the page register and then makes a single read, which shows whether the upper address bits come from that register. It also checks a zero-length burst read, which must make exactly one access, and a stalled request, which must not change while `req_ready` is low.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

   localparam logic [3:0] CMD_RD8  = 4'h1;
   localparam logic [3:0] CMD_RD16 = 4'h2;
   localparam logic [3:0] CMD_RD32 = 4'h3;
   localparam logic [3:0] CMD_RREG = 4'h4;
   localparam logic [3:0] CMD_RBST = 4'h5;
   localparam logic [3:0] CMD_WR8  = 4'h9;
   localparam logic [3:0] CMD_WR16 = 4'hA;
   localparam logic [3:0] CMD_WR32 = 4'hB;
   localparam logic [3:0] CMD_WREG = 4'hC;
   localparam logic [3:0] CMD_WBST = 4'hD;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef struct packed {
      logic       valid;
      logic       is_read;
      logic       is_reg;
      logic       is_burst;
      logic [1:0] size;
   } cmd_info_t;

   typedef enum logic [2:0] {
      ST_HDR, ST_WDATA, ST_BRD, ST_DROP, ST_DONE
   } tlg_state_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/tlg_cmd_decode.sv
module tlg_cmd_decode
   import tlg_pkg::*;
#(
   parameter bit BURST_EN = 1'b1
) (
   input  logic [3:0] code,
   output cmd_info_t  info
);
   logic burst_ok;

   generate
      if (BURST_EN) begin : g_burst
         assign burst_ok = 1'b1;
      end else begin : g_noburst
         assign burst_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      info         = '0;
      info.is_read = ~code[3];
      case (code)
         CMD_RD8,  CMD_WR8:  begin info.valid = 1'b1; info.size = SZ_BYTE; end
         CMD_RD16, CMD_WR16: begin info.valid = 1'b1; info.size = SZ_HALF; end
         CMD_RD32, CMD_WR32: begin info.valid = 1'b1; info.size = SZ_WORD; end
         CMD_RREG, CMD_WREG: begin
            info.valid  = 1'b1;
            info.is_reg = 1'b1;
            info.size   = SZ_WORD;
         end
         CMD_RBST, CMD_WBST: begin
            info.valid    = burst_ok;
            info.is_burst = 1'b1;
            info.size     = SZ_BYTE;
         end
         default: info.valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/tlg_sfr_file.sv
module tlg_sfr_file #(
   parameter int NUM_REGS = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data,
   output logic [19:0]      page_hi
);
   logic [31:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               regs[g] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = regs[rd_idx];
   assign page_hi = regs[0][31:12];
endmodule

// File: rtl/tlg_tx_queue.sv
module tlg_tx_queue #(
   parameter int SLOTS = 5,
   localparam int SR_W = SLOTS * 8,
   localparam int CN_W = $clog2(SLOTS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SR_W-1:0] ld_data,
   input  logic [CN_W-1:0] ld_cnt,
   output logic            tx_valid,
   output logic [7:0]      tx_byte
);
   logic [SR_W-1:0] sr;
   logic [CN_W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= ld_data;
         left <= ld_cnt;
      end else if (left != '0) begin
         sr   <= {sr[SR_W-9:0], 8'h00};
         left <= left - 1'b1;
      end
   end

   assign tx_valid = (left != '0);
   assign tx_byte  = sr[SR_W-1 -: 8];
endmodule

// File: rtl/tlg_decoder.sv
module tlg_decoder
   import tlg_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter bit BURST_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   output logic        tx_valid,
   output logic [7:0]  tx_byte,
   output logic        req_valid,
   input  logic        req_ready,
   output logic        req_write,
   output logic [31:0] req_addr,
   output logic [1:0]  req_size,
   output logic [31:0] req_wdata,
   input  logic        rsp_valid,
   input  logic [31:0] rsp_rdata,
   output logic        write_done,
   output logic        read_done
);
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int LEN_W = 11;
   localparam int CNT_W = LEN_W + 1;

   generate
      if (NUM_REGS < 2 || NUM_REGS > 1024 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two from 2 to 1024");
      end
   endgenerate

   tlg_state_e       st;
   logic [2:0]       hdr_cnt;
   cmd_info_t        info_now, info_q;
   logic [3:0]       b0_q;
   logic [31:0]      addr_q;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] dcnt;
   logic [31:0]      wbuf;
   logic             req_valid_q, req_write_q, req_last_q;
   logic [31:0]      req_addr_q, req_wdata_q;
   logic [1:0]       req_size_q, rd_size_q;
   logic             rd_pend, rd_last_q;
   logic             sfr_we_q;
   logic [31:0]      sfr_wdata_q, sfr_rd;
   logic [19:0]      page_hi;
   logic             write_done_q, read_done_q;

   logic             byte_in, hdr_single, hdr_burst, ack_fire, rsp_take;
   logic             size_ok, reg_ok, single_ok, wr_last;
   logic [11:0]      addr12_now;
   logic [31:0]      burst_addr_now;
   logic [2:0]       nb;
   logic             tx_load;
   logic [39:0]      tx_ld_data;
   logic [2:0]       tx_ld_cnt;

   tlg_cmd_decode #(.BURST_EN(BURST_EN)) u_dec (
      .code (rx_byte[7:4]),
      .info (info_now)
   );

   tlg_sfr_file #(.NUM_REGS(NUM_REGS)) u_sfr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sfr_we_q),
      .wr_idx  (addr_q[IDX_W+1:2]),
      .wr_data (sfr_wdata_q),
      .rd_idx  (addr12_now[IDX_W+1:2]),
      .rd_data (sfr_rd),
      .page_hi (page_hi)
   );

   tlg_tx_queue #(.SLOTS(5)) u_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tx_load),
      .ld_data  (tx_ld_data),
      .ld_cnt   (tx_ld_cnt),
      .tx_valid (tx_valid),
      .tx_byte  (tx_byte)
   );

   always_comb begin
      byte_in        = rx_valid && !cs_n;
      addr12_now     = {b0_q, rx_byte};
      burst_addr_now = {addr_q[23:0], rx_byte};
      case (info_q.size)
         SZ_BYTE: size_ok = 1'b1;
         SZ_HALF: size_ok = ~addr12_now[0];
         default: size_ok = (addr12_now[1:0] == 2'b00);
      endcase
      reg_ok     = (addr12_now[1:0] == 2'b00) && ({22'd0, addr12_now[11:2]} < 32'(NUM_REGS));
      single_ok  = info_q.is_reg ? reg_ok : size_ok;
      hdr_single = byte_in && (st == ST_HDR) && (hdr_cnt == 3'd1) && !info_q.is_burst;
      hdr_burst  = byte_in && (st == ST_HDR) && (hdr_cnt == 3'd5) && info_q.is_burst;
      ack_fire   = (hdr_single && single_ok) || hdr_burst;
      rsp_take   = rsp_valid && rd_pend;
      nb         = info_q.is_reg ? 3'd4 : size_bytes(info_q.size);
      wr_last    = (dcnt[2:0] == nb - 3'd1);

      tx_load    = ack_fire || rsp_take;
      tx_ld_data = '0;
      tx_ld_cnt  = '0;
      if (ack_fire) begin
         if (info_q.is_reg && info_q.is_read) begin
            tx_ld_data = {{b0_q, b0_q} & 8'h00 | {4'h4, 4'h4}, sfr_rd};
            tx_ld_cnt  = 3'd5;
         end else begin
            tx_ld_cnt  = 3'd1;
         end
         if (!(info_q.is_reg && info_q.is_read)) tx_ld_data[39:32] = ack_byte;
      end else if (rsp_take) begin
         case (rd_size_q)
            SZ_BYTE: begin tx_ld_data = {rsp_rdata[7:0], 32'h0};  tx_ld_cnt = 3'd1; end
            SZ_HALF: begin tx_ld_data = {rsp_rdata[15:0], 24'h0}; tx_ld_cnt = 3'd2; end
            default: begin tx_ld_data = {rsp_rdata, 8'h0};        tx_ld_cnt = 3'd4; end
         endcase
      end
   end

   logic [3:0] cmd_q;
   logic [7:0] ack_byte;
   assign ack_byte = {cmd_q, cmd_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_HDR;
         hdr_cnt      <= '0;
         info_q       <= '0;
         cmd_q        <= '0;
         b0_q         <= '0;
         addr_q       <= '0;
         len_q        <= '0;
         dcnt         <= '0;
         wbuf         <= '0;
         req_valid_q  <= 1'b0;
         req_write_q  <= 1'b0;
         req_last_q   <= 1'b0;
         req_addr_q   <= '0;
         req_wdata_q  <= '0;
         req_size_q   <= '0;
         rd_size_q    <= '0;
         rd_pend      <= 1'b0;
         rd_last_q    <= 1'b0;
         sfr_we_q     <= 1'b0;
         sfr_wdata_q  <= '0;
         write_done_q <= 1'b0;
         read_done_q  <= 1'b0;
      end else begin
         write_done_q <= (req_valid_q && req_ready && req_write_q && req_last_q) || sfr_we_q;
         read_done_q  <= rsp_take && rd_last_q;
         sfr_we_q     <= 1'b0;
         if (req_valid_q && req_ready) req_valid_q <= 1'b0;
         if (rsp_take) rd_pend <= 1'b0;

         if (cs_n) begin
            st      <= ST_HDR;
            hdr_cnt <= '0;
         end else if (byte_in) begin
            case (st)
               ST_HDR: begin
                  hdr_cnt <= hdr_cnt + 3'd1;
                  if (hdr_cnt == 3'd0) begin
                     b0_q   <= rx_byte[3:0];
                     cmd_q  <= rx_byte[7:4];
                     info_q <= info_now;
                     if (!info_now.valid) st <= ST_DROP;
                  end else if (!info_q.is_burst) begin
                     addr_q <= {page_hi, addr12_now};
                     dcnt   <= '0;
                     wbuf   <= '0;
                     if (!single_ok) begin
                        st <= ST_DROP;
                     end else if (info_q.is_read) begin
                        st <= ST_DONE;
                        if (info_q.is_reg) begin
                           read_done_q <= 1'b1;
                        end else begin
                           req_valid_q <= 1'b1;
                           req_write_q <= 1'b0;
                           req_last_q  <= 1'b1;
                           req_addr_q  <= {page_hi, addr12_now};
                           req_size_q  <= info_q.size;
                           rd_pend     <= 1'b1;
                           rd_size_q   <= info_q.size;
                           rd_last_q   <= 1'b1;
                        end
                     end else begin
                        st <= ST_WDATA;
                     end
                  end else begin
                     if (hdr_cnt == 3'd1) len_q  <= {b0_q[2:0], rx_byte};
                     else                 addr_q <= burst_addr_now;
                     if (hdr_cnt == 3'd5) begin
                        if (info_q.is_read) begin
                           req_valid_q <= 1'b1;
                           req_write_q <= 1'b0;
                           req_last_q  <= (len_q == '0);
                           req_addr_q  <= burst_addr_now;
                           req_size_q  <= SZ_BYTE;
                           rd_pend     <= 1'b1;
                           rd_size_q   <= SZ_BYTE;
                           rd_last_q   <= (len_q == '0);
                           dcnt        <= CNT_W'(1);
                           st          <= (len_q == '0) ? ST_DONE : ST_BRD;
                        end else begin
                           dcnt <= '0;
                           st   <= ST_WDATA;
                        end
                     end
                  end
               end
               ST_WDATA: begin
                  dcnt <= dcnt + 1'b1;
                  if (!info_q.is_burst) begin
                     wbuf <= {wbuf[23:0], rx_byte};
                     if (wr_last) begin
                        st <= ST_DONE;
                        if (info_q.is_reg) begin
                           sfr_we_q    <= 1'b1;
                           sfr_wdata_q <= {wbuf[23:0], rx_byte};
                        end else begin
                           req_valid_q <= 1'b1;
                           req_write_q <= 1'b1;
                           req_last_q  <= 1'b1;
                           req_addr_q  <= addr_q;
                           req_size_q  <= info_q.size;
                           req_wdata_q <= {wbuf[23:0], rx_byte};
                        end
                     end
                  end else begin
                     req_valid_q <= 1'b1;
                     req_write_q <= 1'b1;
                     req_last_q  <= (dcnt == {1'b0, len_q});
                     req_addr_q  <= addr_q + 32'(dcnt);
                     req_size_q  <= SZ_BYTE;
                     req_wdata_q <= {24'h0, rx_byte};
                     if (dcnt == {1'b0, len_q}) st <= ST_DONE;
                  end
               end
               ST_BRD: begin
                  dcnt        <= dcnt + 1'b1;
                  req_valid_q <= 1'b1;
                  req_write_q <= 1'b0;
                  req_last_q  <= (dcnt == {1'b0, len_q});
                  req_addr_q  <= addr_q + 32'(dcnt);
                  req_size_q  <= SZ_BYTE;
                  rd_pend     <= 1'b1;
                  rd_size_q   <= SZ_BYTE;
                  rd_last_q   <= (dcnt == {1'b0, len_q});
                  if (dcnt == {1'b0, len_q}) st <= ST_DONE;
               end
               default: ;
            endcase
         end
      end
   end

   assign req_valid  = req_valid_q;
   assign req_write  = req_write_q;
   assign req_addr   = req_addr_q;
   assign req_size   = req_size_q;
   assign req_wdata  = req_wdata_q;
   assign write_done = write_done_q;
   assign read_done  = read_done_q;
endmodule

// File: rtl/tlg_decoder_chk.sv
module tlg_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        req_write,
   input logic [31:0] req_addr,
   input logic [31:0] req_wdata,
   input logic [1:0]  req_size,
   input logic        write_done,
   input logic        read_done
);
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                  && $stable(req_write) && $stable(req_size));

   assert_half_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_size == 2'd1) |-> !req_addr[0]);

   assert_word_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_size == 2'd2) |-> (req_addr[1:0] == 2'b00));

   assert_no_reserved_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_size != 2'd3));

   assert_issue_in_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> !$past(cs_n));

   assert_wdone_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      write_done |=> !write_done);

   assert_rdone_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      read_done |=> !read_done);
endmodule

bind tlg_decoder tlg_decoder_chk u_chk (.*);

// File: tb/test_tlg_decoder.sv
module test_tlg_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic        req_valid, req_write, write_done, read_done;
   logic        req_ready = 1'b1;
   logic [31:0] req_addr, req_wdata;
   logic [1:0]  req_size;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   always #2 clk = ~clk;

   tlg_decoder i_tlg_decoder (.*);

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   logic [7:0]  tx_log [16];
   int          tx_n = 0;
   logic [31:0] rq_addr [8];
   logic [31:0] rq_wdata [8];
   logic        rq_wr [8];
   logic [1:0]  rq_sz [8];
   int          rq_n = 0, wd_n = 0, rd_n = 0;
   bit          pend = 0;
   logic [31:0] pend_addr = '0;

   function automatic logic [31:0] memw(input logic [31:0] a);
      return {a[7:0] ^ 8'h3C, a[15:8], ~a[7:0], a[7:0] + 8'h11};
   endfunction

   always @(negedge clk) begin
      rsp_valid = 1'b0;
      if (pend) begin
         rsp_valid = 1'b1;
         rsp_rdata = memw(pend_addr);
         pend      = 0;
      end
      if (req_valid && req_ready) begin
         if (rq_n < 8) begin
            rq_addr[rq_n]  = req_addr;
            rq_wdata[rq_n] = req_wdata;
            rq_wr[rq_n]    = req_write;
            rq_sz[rq_n]    = req_size;
         end
         rq_n++;
         if (!req_write) begin pend = 1; pend_addr = req_addr; end
      end
      if (tx_valid) begin
         if (tx_n < 16) tx_log[tx_n] = tx_byte;
         tx_n++;
      end
      if (write_done) wd_n++;
      if (read_done)  rd_n++;
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic clr;
      @(negedge clk);
      tx_n = 0; rq_n = 0; wd_n = 0; rd_n = 0;
   endtask

   task automatic sel_lo;
      @(negedge clk); cs_n = 1'b0;
   endtask

   task automatic sel_hi;
      @(negedge clk); cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); rx_byte = b; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   typedef struct packed {
      logic [3:0]  cmd;
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  nsend;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'h1, 12'h0AB, 32'h0,         4'd3},
      '{4'h2, 12'h0AC, 32'h0,         4'd4},
      '{4'h2, 12'h0AD, 32'h0,         4'd4},
      '{4'h3, 12'h100, 32'h0,         4'd6},
      '{4'h3, 12'h102, 32'h0,         4'd6},
      '{4'h9, 12'h033, 32'h5E,        4'd3},
      '{4'hA, 12'h034, 32'hBEEF,      4'd4},
      '{4'hB, 12'h038, 32'h01234567,  4'd6},
      '{4'hB, 12'h038, 32'h89ABCDEF,  4'd4},
      '{4'h0, 12'h000, 32'h0,         4'd6},
      '{4'h7, 12'h010, 32'h0,         4'd3},
      '{4'hF, 12'h020, 32'h0,         4'd4},
      '{4'h1, 12'h001, 32'h0,         4'd1},
      '{4'hA, 12'h036, 32'h1234,      4'd3}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
      chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
      chk("R1 done", {30'd0, write_done, read_done}, 32'd0);

      // table of single transfers
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         bit valid = (t.cmd inside {4'h1, 4'h2, 4'h3, 4'h9, 4'hA, 4'hB});
         int n = (t.cmd[1:0] == 2'd1) ? 1 : (t.cmd[1:0] == 2'd2) ? 2 : 4;
         bit align = (n == 1) || (n == 2 && !t.a[0]) || (n == 4 && t.a[1:0] == 2'b00);
         bit wr = t.cmd[3];
         bit hdr_ok = valid && align && (t.nsend >= 2);
         bit full = (t.nsend >= 4'(2 + n));
         string tag;
         logic [31:0] mask = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
         logic [31:0] exp_a = {20'h0, t.a};
         tag = !valid ? "R9" : !align ? "R10" : (t.nsend < 2) ? "R11" :
               (wr && !full) ? "R11" : wr ? "R5" : "R4";
         clr();
         sel_lo();
         for (int i = 0; i < int'(t.nsend); i++) begin
            logic [7:0] b;
            if (i == 0)      b = {t.cmd, t.a[11:8]};
            else if (i == 1) b = t.a[7:0];
            else if (wr)     b = 8'(t.d >> (8 * (n - 1 - (i - 2))));
            else             b = 8'h00;
            put(b);
         end
         sel_hi();
         chk({tag, " tx count"}, tx_n, hdr_ok ? (wr ? 1 : 1 + n) : 0);
         if (hdr_ok) chk("R3 ack byte", {24'd0, tx_log[0]}, {24'd0, t.cmd, t.cmd});
         if (hdr_ok && !wr) begin
            chk("R2 req count", rq_n, 1);
            chk("R2 req addr", rq_addr[0], exp_a);
            chk("R2 req size", {30'd0, rq_sz[0]}, (n == 1) ? 0 : (n == 2) ? 1 : 2);
            chk("R2 req dir", {31'd0, rq_wr[0]}, 0);
            for (int j = 0; j < n; j++)
               chk("R4 read byte", {24'd0, tx_log[1 + j]},
                   {24'd0, 8'(memw(exp_a) >> (8 * (n - 1 - j)))});
            chk("R4 read_done", rd_n, 1);
         end else if (hdr_ok && full) begin
            chk("R5 req count", rq_n, 1);
            chk("R5 req addr", rq_addr[0], exp_a);
            chk("R5 wdata", rq_wdata[0], t.d & mask);
            chk("R5 write_done", wd_n, 1);
         end else begin
            chk({tag, " no request"}, rq_n, 0);
            chk({tag, " no done"}, wd_n + rd_n, 0);
         end
      end

      // R12: stalled request keeps its content
      clr();
      req_ready = 1'b0;
      sel_lo(); put(8'h90); put(8'h40); put(8'h77);
      repeat (4) @(negedge clk);
      chk("R12 held valid", {31'd0, req_valid}, 1);
      chk("R12 held addr", req_addr, 32'h0000_0040);
      chk("R12 held data", req_wdata, 32'h77);
      chk("R12 no done while stalled", wd_n, 0);
      req_ready = 1'b1;
      sel_hi();
      chk("R12 one accept", rq_n, 1);
      chk("R12 done after accept", wd_n, 1);

      // R6: register write and read back
      clr();
      sel_lo(); put(8'hC0); put(8'h04); put(8'hCA); put(8'hFE); put(8'hBA); put(8'hBE); sel_hi();
      chk("R6 reg write ack", {24'd0, tx_log[0]}, 32'hCC);
      chk("R6 reg write no bus", rq_n, 0);
      chk("R6 reg write_done", wd_n, 1);
      clr();
      sel_lo(); put(8'h40); put(8'h04);
      for (int i = 0; i < 4; i++) put(8'h00);
      sel_hi();
      chk("R6 reg read tx count", tx_n, 5);
      chk("R6 reg read ack", {24'd0, tx_log[0]}, 32'h44);
      chk("R6 reg read data", {tx_log[1], tx_log[2], tx_log[3], tx_log[4]}, 32'hCAFEBABE);
      chk("R6 reg read_done", rd_n, 1);
      chk("R6 reg read no bus", rq_n, 0);

      // R10: register index out of range
      clr();
      sel_lo(); put(8'h40); put(8'h10); put(8'h00); sel_hi();
      chk("R10 reg range no ack", tx_n, 0);
      chk("R10 reg range no done", rd_n, 0);

      // R6/R2: page register supplies upper address
      clr();
      sel_lo(); put(8'hC0); put(8'h00); put(8'h12); put(8'h34); put(8'h50); put(8'h00); sel_hi();
      clr();
      sel_lo(); put(8'h10); put(8'hAB); put(8'h00); sel_hi();
      chk("R2 paged addr", rq_addr[0], 32'h1234_50AB);
      chk("R2 paged data", {24'd0, tx_log[1]}, {24'd0, memw(32'h1234_50AB)[7:0]});

      // R7: burst write, reserved bit set
      clr();
      sel_lo();
      put(8'hD8); put(8'h02); put(8'h00); put(8'h00); put(8'h10); put(8'h01);
      put(8'h11); put(8'h22); put(8'h33);
      sel_hi();
      chk("R7 ack", {24'd0, tx_log[0]}, 32'hDD);
      chk("R7 write count", rq_n, 3);
      for (int j = 0; j < 3; j++) begin
         chk("R7 addr", rq_addr[j], 32'h0000_1001 + 32'(j));
         chk("R7 data", rq_wdata[j], 32'h11 * 32'(j + 1));
         chk("R7 size", {30'd0, rq_sz[j]}, 0);
      end
      chk("R7 write_done once", wd_n, 1);

      // R8: burst read of four bytes
      clr();
      sel_lo();
      put(8'h50); put(8'h03); put(8'h00); put(8'h00); put(8'h02); put(8'h00);
      for (int i = 0; i < 3; i++) put(8'h00);
      sel_hi();
      chk("R8 read count", rq_n, 4);
      chk("R8 tx count", tx_n, 5);
      chk("R8 ack", {24'd0, tx_log[0]}, 32'h55);
      for (int j = 0; j < 4; j++)
         chk("R8 byte", {24'd0, tx_log[1 + j]}, {24'd0, memw(32'h200 + 32'(j))[7:0]});
      chk("R8 read_done", rd_n, 1);

      // R8 boundary: zero length burst read moves one byte
      clr();
      sel_lo();
      put(8'h50); put(8'h00); put(8'h00); put(8'h00); put(8'h03); put(8'h10);
      put(8'h00); put(8'h00);
      sel_hi();
      chk("R8 len0 one read", rq_n, 1);
      chk("R8 len0 addr", rq_addr[0], 32'h0000_0310);
      chk("R8 len0 tx count", tx_n, 2);

      // R11: burst write cut short
      clr();
      sel_lo();
      put(8'hD0); put(8'h03); put(8'h00); put(8'h00); put(8'h20); put(8'h00);
      put(8'hA1); put(8'hA2);
      sel_hi();
      chk("R11 partial burst writes", rq_n, 2);
      chk("R11 no write_done", wd_n, 0);

      // R11: burst header cut short
      clr();
      sel_lo(); put(8'h50); put(8'h00); put(8'h00); sel_hi();
      chk("R11 short burst header", tx_n + rq_n, 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule